// File: doc/BRIEF.md
# Interruptible Block Memory Copy Engine

This block is the sequencer behind a block-move operation. Given a source pointer, a destination pointer and a byte count, it copies bytes over a single-port byte memory. The bus carries one access per cycle and read data returns on the cycle after the read.

Before any data moves, the engine makes two throw-away reads: first at the source address, then at the destination address. Each byte is then copied as a read cycle followed by a write cycle.

There are two modes:
- **Word-count mode** uses the full 16-bit count. It can be stopped between bytes by the non-maskable interrupt, or by an unmasked maskable request. When it stops, its pointer and count registers are left ready for a restart.
- **Byte-count mode** copies only the low 8 bits' worth of bytes. It ignores every interrupt until it finishes.

The surrounding processor restarts an interrupted copy by issuing it again with the register values the engine left behind. It keeps doing so until the count reads zero.

Top module: `blk_copy_engine`

## Requirements
- R1: After reset the engine is idle: busy, done and yield low, no memory request, pointers and count zero. A start pulse while idle loads the registers, and busy is then high for exactly 4 + 2m cycles, where m is the number of bytes moved in that run.
- R2: The first two memory accesses of every run are reads (write enable low), first at the source pointer, then at the destination pointer.
- R3: A run that moves m bytes makes exactly 2(m + 1) memory accesses, including m = 0.
- R4: Each byte is a read at the source pointer followed in the next cycle by a write, at the destination pointer, of the data returned by that read. After the write both pointers have advanced by one and the count has dropped by one.
- R5: In word-count mode (mode_i = 1) the count is all 16 bits, so counts above 255 copy in full.
- R6: In byte-count mode (mode_i = 0) only count bits [7:0] give the length and decrement. Bits [15:8] keep their loaded value.
- R7: In word-count mode, an interrupt (nmi_i high, or irq_i high with irq_mask_i low) seen at a byte boundary stops the run after the byte in flight. yield_o then pulses, and the registers hold the next source address, the next destination address and the bytes still to copy.
- R8: In word-count mode, irq_i has no effect while irq_mask_i is high.
- R9: In byte-count mode neither nmi_i nor irq_i stops the run.
- R10: Restarting an interrupted run with the left-over register values completes the copy, and the destination memory ends identical to an uninterrupted copy.
- R11: done_o pulses for one cycle in the cycle after busy falls on a finished run, with the count then zero. A start pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| mode_i | input | 1 | 1 = word-count (interruptible), 0 = byte-count |
| src_i | input | 32 | Source pointer to load |
| dst_i | input | 32 | Destination pointer to load |
| cnt_i | input | 16 | Count to load |
| irq_i | input | 1 | Maskable interrupt request |
| irq_mask_i | input | 1 | 1 = maskable request masked |
| nmi_i | input | 1 | Non-maskable interrupt request |
| mem_req_o | output | 1 | Memory access this cycle |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | 32 | Byte address |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data, valid the cycle after a read |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle pulse: run completed |
| yield_o | output | 1 | One-cycle pulse: run stopped by an interrupt |
| src_o | output | 32 | Current source pointer |
| dst_o | output | 32 | Current destination pointer |
| cnt_o | output | 16 | Current count |

## Verification
The assertions assume that the memory returns read data exactly one cycle after a read and that source and destination areas do not overlap. They also assume interrupt requests are levels held until the engine yields.

The bench memory model is a synchronous-read array, and every vector uses disjoint source and destination windows. Each interrupt is raised at a negative edge inside a known write cycle and held until busy falls. That keeps the bytes-moved count predictable from the vector alone.

// File: rtl/blkcp_pkg.sv
package blkcp_pkg;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_SETUP = 3'd1,
    S_PRB_S = 3'd2,
    S_PRB_D = 3'd3,
    S_RD    = 3'd4,
    S_WR    = 3'd5,
    S_FIN   = 3'd6
  } seq_state_t;

  localparam logic MODE_BYTE = 1'b0;
  localparam logic MODE_WORD = 1'b1;

endpackage

// File: rtl/blkcp_irq_gate.sv
module blkcp_irq_gate (
  input  logic word_mode,
  input  logic nmi,
  input  logic irq,
  input  logic irq_mask,
  output logic take
);
  // Byte-count runs never yield; word-count runs yield on NMI or an unmasked request.
  assign take = word_mode & (nmi | (irq & ~irq_mask));
endmodule

// File: rtl/blkcp_regs.sv
module blkcp_regs #(
  parameter int AW  = 32,
  parameter int CW  = 16,
  parameter int BCW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          step,
  input  logic          mode_in,
  input  logic [AW-1:0] src_in,
  input  logic [AW-1:0] dst_in,
  input  logic [CW-1:0] cnt_in,
  output logic          mode_q,
  output logic [AW-1:0] src_q,
  output logic [AW-1:0] dst_q,
  output logic [CW-1:0] cnt_q,
  output logic          empty,
  output logic          last
);
  localparam int HW = CW - BCW;

  logic [BCW-1:0] lo;
  assign lo = cnt_q[BCW-1:0];

  always_comb begin
    if (mode_q) begin
      empty = (cnt_q == '0);
      last  = (cnt_q == CW'(1));
    end else begin
      empty = (lo == '0);
      last  = (lo == BCW'(1));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= 1'b0;
      src_q  <= '0;
      dst_q  <= '0;
      cnt_q  <= '0;
    end else if (load) begin
      mode_q <= mode_in;
      src_q  <= src_in;
      dst_q  <= dst_in;
      cnt_q  <= cnt_in;
    end else if (step) begin
      src_q <= src_q + AW'(1);
      dst_q <= dst_q + AW'(1);
      if (mode_q) cnt_q <= cnt_q - CW'(1);
      else        cnt_q[BCW-1:0] <= lo - BCW'(1);
    end
  end

  // R4: a step advances both pointers by exactly one
  p_ptr_step_r4: assert property (@(posedge clk) disable iff (rst)
    (step && !load) |=> (src_q == $past(src_q) + AW'(1)) && (dst_q == $past(dst_q) + AW'(1)));

  generate
    if (HW > 0) begin : g_hi
      // R6: in byte-count mode the upper count bits never move
      p_upper_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!load && !mode_q) |=> $stable(cnt_q[CW-1:BCW]));
    end
  endgenerate
endmodule

// File: rtl/blkcp_seq.sv
module blkcp_seq
  import blkcp_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic take,
  input  logic empty,
  input  logic last,
  output logic load,
  output logic step,
  output logic busy,
  output logic done,
  output logic yield,
  output logic mem_req,
  output logic mem_we,
  output logic sel_dst
);
  seq_state_t st, nx;
  logic brk_q, brk_d;

  always_comb begin
    nx    = st;
    brk_d = brk_q;
    case (st)
      S_IDLE:  if (start) begin nx = S_SETUP; brk_d = 1'b0; end
      S_SETUP: nx = S_PRB_S;
      S_PRB_S: nx = S_PRB_D;
      S_PRB_D: begin
        if (empty)     nx = S_FIN;
        else if (take) begin nx = S_FIN; brk_d = 1'b1; end
        else           nx = S_RD;
      end
      S_RD:    nx = S_WR;
      S_WR: begin
        if (last)      nx = S_FIN;
        else if (take) begin nx = S_FIN; brk_d = 1'b1; end
        else           nx = S_RD;
      end
      S_FIN:   nx = S_IDLE;
      default: nx = S_IDLE;
    endcase
  end

  assign load    = (st == S_IDLE) && start;
  assign step    = (st == S_WR);
  assign busy    = (st != S_IDLE);
  assign mem_req = (st == S_PRB_S) || (st == S_PRB_D) || (st == S_RD) || (st == S_WR);
  assign mem_we  = (st == S_WR);
  assign sel_dst = (st == S_PRB_D) || (st == S_WR);

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= S_IDLE;
      brk_q <= 1'b0;
      done  <= 1'b0;
      yield <= 1'b0;
    end else begin
      st    <= nx;
      brk_q <= brk_d;
      done  <= (st == S_FIN) && !brk_q;
      yield <= (st == S_FIN) && brk_q;
    end
  end

  // R4: every write is immediately preceded by a read
  p_wr_after_rd_r4: assert property (@(posedge clk) disable iff (rst)
    (st == S_WR) |-> ($past(st) == S_RD));
  // R2: the destination probe follows the source probe
  p_probe_order_r2: assert property (@(posedge clk) disable iff (rst)
    (st == S_PRB_D) |-> ($past(st) == S_PRB_S));
  // R3: no bus traffic outside a run
  p_req_in_run_r3: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> busy);
  // R11: completion pulse is single and exclusive
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_done_excl_r11: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && !yield));
endmodule

// File: rtl/blk_copy_engine.sv
module blk_copy_engine #(
  parameter int AW  = 32,
  parameter int CW  = 16,
  parameter int BCW = 8,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          mode_i,
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] dst_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          irq_i,
  input  logic          irq_mask_i,
  input  logic          nmi_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          yield_o,
  output logic [AW-1:0] src_o,
  output logic [AW-1:0] dst_o,
  output logic [CW-1:0] cnt_o
);
  logic load, step, take, empty, last, sel_dst, mode_q;

  blkcp_irq_gate u_gate (
    .word_mode (mode_q),
    .nmi       (nmi_i),
    .irq       (irq_i),
    .irq_mask  (irq_mask_i),
    .take      (take)
  );

  blkcp_regs #(.AW(AW), .CW(CW), .BCW(BCW)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .step    (step),
    .mode_in (mode_i),
    .src_in  (src_i),
    .dst_in  (dst_i),
    .cnt_in  (cnt_i),
    .mode_q  (mode_q),
    .src_q   (src_o),
    .dst_q   (dst_o),
    .cnt_q   (cnt_o),
    .empty   (empty),
    .last    (last)
  );

  blkcp_seq u_seq (
    .clk     (clk),
    .rst     (rst),
    .start   (start_i),
    .take    (take),
    .empty   (empty),
    .last    (last),
    .load    (load),
    .step    (step),
    .busy    (busy_o),
    .done    (done_o),
    .yield   (yield_o),
    .mem_req (mem_req_o),
    .mem_we  (mem_we_o),
    .sel_dst (sel_dst)
  );

  assign mem_addr_o  = sel_dst ? dst_o : src_o;
  assign mem_wdata_o = mem_rdata_i;

  // R9: a byte-count run never ends by yielding
  p_byte_no_yield_r9: assert property (@(posedge clk) disable iff (rst)
    yield_o |-> mode_q);
  // R7: a yield leaves work outstanding
  p_yield_left_r7: assert property (@(posedge clk) disable iff (rst)
    yield_o |-> !empty);
  // R8: a yield traces back to NMI or an unmasked request two cycles earlier
  p_yield_cause_r8: assert property (@(posedge clk) disable iff (rst)
    yield_o |-> ($past(nmi_i, 2) || ($past(irq_i, 2) && !$past(irq_mask_i, 2))));
  // R11: a completed run has nothing left to copy
  p_done_empty_r11: assert property (@(posedge clk) disable iff (rst)
    done_o |-> empty);
endmodule

// File: tb/sim_blk_copy_engine.sv
module sim_blk_copy_engine;
  typedef struct packed {
    logic        mode;
    logic [9:0]  src;
    logic [9:0]  dst;
    logic [15:0] cnt;
    logic [15:0] k;     // byte boundary at which a request is raised
    logic [1:0]  kind;  // 0 none, 1 nmi, 2 irq, 3 irq masked
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 10'd0,   10'd512, 16'd0,     16'd0,   2'd0},
    '{1'b1, 10'd16,  10'd600, 16'd5,     16'd0,   2'd0},
    '{1'b0, 10'd40,  10'd700, 16'h1207,  16'd0,   2'd0},
    '{1'b1, 10'd100, 10'd520, 16'd12,    16'd4,   2'd1},
    '{1'b1, 10'd200, 10'd800, 16'd9,     16'd0,   2'd2},
    '{1'b1, 10'd10,  10'd900, 16'd6,     16'd2,   2'd3},
    '{1'b0, 10'd64,  10'd640, 16'd9,     16'd3,   2'd1},
    '{1'b1, 10'd0,   10'd512, 16'd300,   16'd100, 2'd1},
    '{1'b0, 10'd0,   10'd700, 16'h00FF,  16'd0,   2'd0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0, mode_i = 1'b0;
  logic [31:0] src_i = '0, dst_i = '0;
  logic [15:0] cnt_i = '0;
  logic        irq_i = 1'b0, irq_mask_i = 1'b0, nmi_i = 1'b0;
  logic        mem_req_o, mem_we_o, busy_o, done_o, yield_o;
  logic [31:0] mem_addr_o, src_o, dst_o;
  logic [7:0]  mem_wdata_o;
  logic [7:0]  mem_rdata_i = '0;
  logic [15:0] cnt_o;

  always #5 clk = ~clk;

  blk_copy_engine u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .mode_i(mode_i),
    .src_i(src_i), .dst_i(dst_i), .cnt_i(cnt_i),
    .irq_i(irq_i), .irq_mask_i(irq_mask_i), .nmi_i(nmi_i),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
    .busy_o(busy_o), .done_o(done_o), .yield_o(yield_o),
    .src_o(src_o), .dst_o(dst_o), .cnt_o(cnt_o)
  );

  logic [7:0] mem   [1024];
  logic [7:0] ref_m [1024];
  logic       init_go = 1'b0;
  int         seed = 0;

  function automatic logic [7:0] pat(input int i, input int s);
    return 8'(i * 13 + s * 29 + 1);
  endfunction

  always @(posedge clk) begin
    if (init_go) begin
      for (int i = 0; i < 1024; i++) mem[i] <= pat(i, seed);
    end else if (mem_req_o) begin
      if (mem_we_o) mem[mem_addr_o[9:0]] <= mem_wdata_o;
      mem_rdata_i <= mem[mem_addr_o[9:0]];
    end
  end

  int busy_cnt, acc_n;
  logic        a0_we, a1_we;
  logic [31:0] a0_ad, a1_ad;
  always @(negedge clk) begin
    if (busy_o) busy_cnt++;
    if (mem_req_o) begin
      if (acc_n == 0) begin a0_we = mem_we_o; a0_ad = mem_addr_o; end
      if (acc_n == 1) begin a1_we = mem_we_o; a1_ad = mem_addr_o; end
      acc_n++;
    end
  end

  int total = 0, fails = 0;
  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run(input logic md, input logic [31:0] s, input logic [31:0] d,
                     input logic [15:0] c, input int k, input int kind,
                     input logic mid_start);
    irq_mask_i = (kind == 3);
    irq_i = (kind == 2 || kind == 3) && k == 0;
    nmi_i = (kind == 1) && k == 0;
    @(negedge clk);
    busy_cnt = 0; acc_n = 0;
    start_i = 1'b1; mode_i = md; src_i = s; dst_i = d; cnt_i = c;
    @(negedge clk);
    start_i = 1'b0;
    if (mid_start) begin
      @(negedge clk);
      start_i = 1'b1; src_i = 32'd5; dst_i = 32'd5; cnt_i = 16'd50;
      @(negedge clk);
      start_i = 1'b0;
    end
    if (k > 0 && kind != 0) begin
      repeat (2 + 2 * k) @(negedge clk);
      if (kind == 1) nmi_i = 1'b1; else irq_i = 1'b1;
    end
    for (int g = 0; g < 100000 && busy_o; g++) @(negedge clk);
    irq_i = 1'b0; nmi_i = 1'b0; irq_mask_i = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++; total++;
    $display("FAIL R1 watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(!busy_o && !done_o && !yield_o, "R1", "idle flags after reset", busy_o, 0);
    chk(!mem_req_o, "R1", "no request after reset", mem_req_o, 0);
    chk(cnt_o == 0 && src_o == 0 && dst_o == 0, "R1", "registers zero after reset", cnt_o, 0);

    for (int v = 0; v < NV; v++) begin
      vec_t x;
      int n, m;
      logic [15:0] ecnt;
      x = VECS[v];
      n = x.mode ? int'(x.cnt) : int'(x.cnt[7:0]);
      m = (x.mode && (x.kind == 1 || x.kind == 2) && int'(x.k) < n) ? int'(x.k) : n;
      seed = v;
      @(negedge clk); init_go = 1'b1;
      @(negedge clk); init_go = 1'b0;
      for (int i = 0; i < 1024; i++) ref_m[i] = pat(i, v);
      for (int j = 0; j < n; j++) ref_m[int'(x.dst) + j] = pat(int'(x.src) + j, v);

      run(x.mode, 32'(x.src), 32'(x.dst), x.cnt, int'(x.k), int'(x.kind), 1'b0);
      chk(busy_cnt == 4 + 2 * m, "R1", "busy cycles", busy_cnt, 4 + 2 * m);
      chk(acc_n == 2 * (m + 1), "R3", "access count", acc_n, 2 * (m + 1));
      chk(!a0_we && a0_ad == 32'(x.src), "R2", "first probe at source", a0_ad, x.src);
      chk(!a1_we && a1_ad == 32'(x.dst), "R2", "second probe at destination", a1_ad, x.dst);
      chk(src_o == 32'(x.src) + 32'(m) && dst_o == 32'(x.dst) + 32'(m), "R4",
          "pointers advanced", src_o, 32'(x.src) + 32'(m));
      ecnt = x.mode ? x.cnt - 16'(m) : {x.cnt[15:8], 8'(x.cnt[7:0] - 8'(m))};
      chk(cnt_o == ecnt, x.mode ? "R5" : "R6", "count left", cnt_o, ecnt);
      if (m < n) begin
        chk(yield_o && !done_o, "R7", "yield pulse on interrupt", yield_o, 1);
      end else begin
        chk(done_o && !yield_o, "R11", "done pulse on completion", done_o, 1);
        if (x.kind == 3) chk(!yield_o, "R8", "masked request ignored", yield_o, 0);
        if (!x.mode && x.kind != 0) chk(!yield_o, "R9", "byte mode ignores interrupt", yield_o, 0);
      end
      @(negedge clk);
      chk(!done_o && !yield_o, "R11", "pulse lasts one cycle", done_o, 0);
      if (m < n) begin
        run(x.mode, src_o, dst_o, cnt_o, 0, 0, 1'b0);
        chk(busy_cnt == 4 + 2 * (n - m) && done_o, "R10", "restart busy cycles",
            busy_cnt, 4 + 2 * (n - m));
        chk(cnt_o == 0, "R10", "restart count zero", cnt_o, 0);
      end
      begin
        int bad = 0;
        for (int i = 0; i < 1024; i++) if (mem[i] !== ref_m[i]) bad++;
        chk(bad == 0, m < n ? "R10" : "R4", "memory mismatches", bad, 0);
      end
    end

    // R11: start while busy is ignored
    run(1'b1, 32'd16, 32'd600, 16'd4, 0, 0, 1'b1);
    chk(busy_cnt == 12 && cnt_o == 0 && src_o == 32'd20, "R11",
        "start during run ignored", busy_cnt, 12);

    // R1: reset during a run returns to idle
    @(negedge clk);
    start_i = 1'b1; mode_i = 1'b1; src_i = 32'd0; dst_i = 32'd512; cnt_i = 16'd20;
    @(negedge clk); start_i = 1'b0;
    repeat (6) @(negedge clk);
    rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk(!busy_o && !mem_req_o && cnt_o == 0, "R1", "reset mid-run", busy_o, 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule